// File: doc/BRIEF.md
# Register Specifier Redirection Unit

This block is the register-access front end of a small embedded pipeline. It owns sixteen architected 32-bit registers and five small alternate storage structures. Every access arrives with a 4-bit register specifier, and a lookup table indexed by that specifier decides where the access goes. A specifier with no binding reads and writes the plain register file. A bound specifier is steered into its structure, and that structure applies its own ordering rule. One architected name can then carry a sequence of values, such as a value carried across loop iterations or a group of temporaries that are released in reverse order.

Structures 1 to 3 are non-destructive delay queues. Structure 4 is a draining FIFO by default; when the `S4_STACK` parameter is set it is a stack. Structure 5 is a circular buffer. A single bind/release command takes a specifier, a depth setting and a structure number. It updates the table at the next clock edge and reinitialises the chosen structure at that same edge. A structure may be bound to only one specifier at a time. The unit provides two combinational read ports and one write port that is registered on the clock edge.

Top module: `regmap_unit`

## Requirements
- R1: An unbound specifier reads the register file combinationally in the same cycle, and writes take effect at the clock edge. All registers are zero after reset. A read port whose enable is low returns zero.
- R2: A write to a bound specifier goes only to its structure and leaves the register file entry of the same number unchanged. This is visible after the binding is released.
- R3: An accepted bind command steers accesses from the next cycle on. A release command (`map_unmap`=1) returns the specifier to the register file from the next cycle on.
- R4: The depth setting `map_cfg` selects 1 to 8 entries. A value of 0, or a value above 8, gives a depth of 8.
- R5: Structures 1 to 3 (`map_target` 1, 2, 3) behave as delay queues of depth D. A read returns the value written D writes earlier and does not remove it. A write when D values are held discards the oldest value.
- R6: Structure 4 in its default form is a FIFO. Each read removes the head.
- R7: Structure 4 with `S4_STACK`=1 is a stack. Reads return values in reverse order of writing, and each read removes the top.
- R8: Structure 5 is a circular buffer. The read pointer and the write pointer each advance by one per access and wrap modulo the depth. Reads do not remove data.
- R9: A read of an empty FIFO or stack, or of a delay queue holding fewer than D values, returns zero and sets `underflow` bit s-1 for structure s. A write to a full FIFO or stack is dropped and sets `overflow` bit s-1. Both flags stay set until that structure is bound again.
- R10: When both read ports read the same bound specifier in one cycle, both ports return the same value and the structure advances only once.
- R11: A bind command is rejected in either of two cases: the target is 0 or above 5, or the target is already bound to a different specifier. A rejected command leaves the table unchanged and raises `map_err` for exactly the following cycle. An accepted command leaves `map_err` low.
- R12: Binding a structure, including binding it again to the same specifier, empties it and resets its pointers and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_spec | input | 4 | Read port 0 specifier |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_spec | input | 4 | Read port 1 specifier |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 4 | Write specifier |
| wr_data | input | 32 | Write data |
| map_valid | input | 1 | Bind/release command strobe |
| map_unmap | input | 1 | 1 = release, 0 = bind |
| map_spec | input | 4 | Specifier to bind or release |
| map_cfg | input | 4 | Depth setting |
| map_target | input | 3 | Structure number 1..5 |
| map_err | output | 1 | Rejected command, one-cycle pulse |
| underflow | output | 5 | Sticky underflow flags, bit s-1 for structure s |
| overflow | output | 5 | Sticky overflow flags, bit s-1 for structure s |

## Verification
The same stimulus drives two instances at once, one with a FIFO and one with a stack in slot 4. A single write burst followed by reads therefore separates first-in from last-in ordering, and a dual-port read of one specifier shows whether the structure advanced once or twice. The delay queue is tested with reads before it fills, repeated reads without writes, and a write after it fills, which separates delay behaviour from draining behaviour. The circular buffer is written past its clamped depth, so the wrap of each pointer shows up in the values read back. Rejected bind commands are driven with a busy target and with out-of-range targets. Release commands show that register-file contents survived while the specifier was bound.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  typedef enum logic [1:0] {
    K_DELAY = 2'd0,
    K_DRAIN = 2'd1,
    K_STACK = 2'd2,
    K_RING  = 2'd3
  } skind_e;

  // depth setting to effective depth: 0 or over the limit means the limit
  function automatic int clamp_depth(input int cfg, input int maxd);
    return (cfg == 0 || cfg > maxd) ? maxd : cfg;
  endfunction

  // pointer increment wrapping at the configured depth
  function automatic int wrap_next(input int p, input int d);
    return (p + 1 >= d) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/regmap_rf.sv
module regmap_rf #(
  parameter int DW    = 32,
  parameter int NSPEC = 16,
  localparam int SW   = $clog2(NSPEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [SW-1:0] ra1,
  output logic [DW-1:0] rd1,
  input  logic          we,
  input  logic [SW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs [NSPEC];

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSPEC; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end
endmodule

// File: rtl/regmap_table.sv
module regmap_table #(
  parameter int NSPEC = 16,
  parameter int NSTR  = 5,
  localparam int SW   = $clog2(NSPEC),
  localparam int TW   = $clog2(NSTR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_unmap,
  input  logic [SW-1:0]             cmd_spec,
  input  logic [TW-1:0]             cmd_tgt,
  output logic [NSPEC-1:0]          ent_vld,
  output logic [NSPEC-1:0][TW-1:0]  ent_tgt,
  output logic                      accept_map,
  output logic [NSTR-1:0]           init_vec,
  output logic                      err
);
  logic [NSTR-1:0] own_vld;
  logic [SW-1:0]   own_spec [NSTR];
  logic            tgt_ok, busy, accept_unmap, reject;
  logic [NSTR-1:0] free_vec;
  logic            cur_vld;
  logic [TW-1:0]   cur_tgt;

  assign cur_vld = ent_vld[cmd_spec];
  assign cur_tgt = ent_tgt[cmd_spec];
  assign tgt_ok  = (cmd_tgt != '0) && (int'(cmd_tgt) <= NSTR);

  always_comb begin
    busy = 1'b0;
    for (int s = 0; s < NSTR; s++)
      if (cmd_tgt == TW'(s + 1) && own_vld[s] && own_spec[s] != cmd_spec) busy = 1'b1;
  end

  assign accept_map   = cmd_valid && !cmd_unmap && tgt_ok && !busy;
  assign accept_unmap = cmd_valid && cmd_unmap;
  assign reject       = cmd_valid && !cmd_unmap && !accept_map;

  always_comb begin
    for (int s = 0; s < NSTR; s++) begin
      init_vec[s] = accept_map && cmd_tgt == TW'(s + 1);
      free_vec[s] = cur_vld && cur_tgt == TW'(s + 1) &&
                    (accept_unmap || (accept_map && cmd_tgt != cur_tgt));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_tgt <= '0;
      own_vld <= '0;
      err     <= 1'b0;
      for (int s = 0; s < NSTR; s++) own_spec[s] <= '0;
    end else begin
      err <= reject;
      if (accept_map) begin
        ent_vld[cmd_spec] <= 1'b1;
        ent_tgt[cmd_spec] <= cmd_tgt;
      end else if (accept_unmap) begin
        ent_vld[cmd_spec] <= 1'b0;
      end
      for (int s = 0; s < NSTR; s++) begin
        if (init_vec[s]) begin
          own_vld[s]  <= 1'b1;
          own_spec[s] <= cmd_spec;
        end else if (free_vec[s]) begin
          own_vld[s] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/regmap_struct.sv
module regmap_struct
  import regmap_pkg::*;
#(
  parameter skind_e KIND = K_DRAIN,
  parameter int     DW   = 32,
  parameter int     MAXD = 8,
  localparam int    PW   = $clog2(MAXD),
  localparam int    CW   = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [CW-1:0] init_depth,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          unf_ev,
  output logic          ovf_ev,
  output logic          unf_flag,
  output logic          ovf_flag
);
  logic [DW-1:0] mem [MAXD];
  logic [CW-1:0] depth, cnt;
  logic [PW-1:0] rptr, wptr, top_idx;
  logic          full, empty, pop, push;

  assign full    = (cnt == depth);
  assign empty   = (cnt == '0);
  assign top_idx = PW'(cnt - CW'(1));

  always_comb begin
    rd_data = '0;
    pop     = 1'b0;
    push    = 1'b0;
    unf_ev  = 1'b0;
    ovf_ev  = 1'b0;
    case (KIND)
      K_DELAY: begin
        if (full) rd_data = mem[wptr];
        unf_ev = rd_en && !full;
        push   = wr_en;
      end
      K_DRAIN: begin
        if (!empty) rd_data = mem[rptr];
        pop    = rd_en && !empty;
        unf_ev = rd_en && empty;
        push   = wr_en && (!full || pop);
        ovf_ev = wr_en && !push;
      end
      K_STACK: begin
        if (!empty) rd_data = mem[top_idx];
        pop    = rd_en && !empty;
        unf_ev = rd_en && empty;
        push   = wr_en && (!full || pop);
        ovf_ev = wr_en && !push;
      end
      default: begin
        rd_data = mem[rptr];
        pop     = rd_en;
        push    = wr_en;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXD; i++) mem[i] <= '0;
      depth    <= CW'(MAXD);
      cnt      <= '0;
      rptr     <= '0;
      wptr     <= '0;
      unf_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else if (init) begin
      depth    <= init_depth;
      cnt      <= '0;
      rptr     <= '0;
      wptr     <= '0;
      unf_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (unf_ev) unf_flag <= 1'b1;
      if (ovf_ev) ovf_flag <= 1'b1;
      case (KIND)
        K_DELAY: begin
          if (push) begin
            mem[wptr] <= wr_data;
            wptr      <= PW'(wrap_next(int'(wptr), int'(depth)));
            if (!full) cnt <= cnt + CW'(1);
          end
        end
        K_DRAIN: begin
          if (pop) rptr <= PW'(wrap_next(int'(rptr), int'(depth)));
          if (push) begin
            mem[wptr] <= wr_data;
            wptr      <= PW'(wrap_next(int'(wptr), int'(depth)));
          end
          cnt <= cnt + CW'(push) - CW'(pop);
        end
        K_STACK: begin
          if (push) begin
            if (pop) mem[top_idx] <= wr_data;
            else     mem[cnt[PW-1:0]] <= wr_data;
          end
          cnt <= cnt + CW'(push) - CW'(pop);
        end
        default: begin
          if (push) begin
            mem[wptr] <= wr_data;
            wptr      <= PW'(wrap_next(int'(wptr), int'(depth)));
          end
          if (pop) rptr <= PW'(wrap_next(int'(rptr), int'(depth)));
        end
      endcase
    end
  end
endmodule

// File: rtl/regmap_unit.sv
module regmap_unit
  import regmap_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NSPEC    = 16,
  parameter int NSTR     = 5,
  parameter int MAXD     = 8,
  parameter bit S4_STACK = 1'b0,
  localparam int SW      = $clog2(NSPEC),
  localparam int TW      = $clog2(NSTR + 1),
  localparam int CW      = $clog2(MAXD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd0_en,
  input  logic [SW-1:0]   rd0_spec,
  output logic [DW-1:0]   rd0_data,
  input  logic            rd1_en,
  input  logic [SW-1:0]   rd1_spec,
  output logic [DW-1:0]   rd1_data,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_spec,
  input  logic [DW-1:0]   wr_data,
  input  logic            map_valid,
  input  logic            map_unmap,
  input  logic [SW-1:0]   map_spec,
  input  logic [CW-1:0]   map_cfg,
  input  logic [TW-1:0]   map_target,
  output logic            map_err,
  output logic [NSTR-1:0] underflow,
  output logic [NSTR-1:0] overflow
);
  logic [NSPEC-1:0]         ent_vld;
  logic [NSPEC-1:0][TW-1:0] ent_tgt;
  logic                     map_accept;
  logic [NSTR-1:0]          init_vec;
  logic [CW-1:0]            map_depth;

  logic          rd0_hit, rd1_hit, wr_hit;
  logic [TW-1:0] rd0_tgt, rd1_tgt, wr_tgt;
  logic [DW-1:0] rf_rd0, rf_rd1, s0_val, s1_val;
  logic          rf_we;

  logic [NSTR-1:0] s_rd, s_wr, s_unf_ev, s_ovf_ev;
  logic [DW-1:0]   s_data [NSTR];

  assign map_depth = CW'(clamp_depth(int'(map_cfg), MAXD));

  regmap_table #(.NSPEC(NSPEC), .NSTR(NSTR)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(map_valid), .cmd_unmap(map_unmap),
    .cmd_spec(map_spec), .cmd_tgt(map_target),
    .ent_vld(ent_vld), .ent_tgt(ent_tgt),
    .accept_map(map_accept), .init_vec(init_vec), .err(map_err)
  );

  assign rd0_hit = ent_vld[rd0_spec];
  assign rd1_hit = ent_vld[rd1_spec];
  assign wr_hit  = ent_vld[wr_spec];
  assign rd0_tgt = ent_tgt[rd0_spec];
  assign rd1_tgt = ent_tgt[rd1_spec];
  assign wr_tgt  = ent_tgt[wr_spec];
  assign rf_we   = wr_en && !wr_hit;

  regmap_rf #(.DW(DW), .NSPEC(NSPEC)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra0(rd0_spec), .rd0(rf_rd0),
    .ra1(rd1_spec), .rd1(rf_rd1),
    .we(rf_we), .wa(wr_spec), .wd(wr_data)
  );

  // steering of each port to its structure; a dual read counts once
  always_comb begin
    for (int s = 0; s < NSTR; s++) begin
      s_rd[s] = (rd0_en && rd0_hit && rd0_tgt == TW'(s + 1)) ||
                (rd1_en && rd1_hit && rd1_tgt == TW'(s + 1));
      s_wr[s] = wr_en && wr_hit && wr_tgt == TW'(s + 1);
    end
  end

  generate
    for (genvar g = 0; g < NSTR; g++) begin : g_str
      localparam skind_e KSEL = (g == NSTR - 1) ? K_RING :
                                (g == NSTR - 2) ? (S4_STACK ? K_STACK : K_DRAIN) :
                                K_DELAY;
      regmap_struct #(.KIND(KSEL), .DW(DW), .MAXD(MAXD)) u_str (
        .clk(clk), .rst_n(rst_n),
        .init(init_vec[g]), .init_depth(map_depth),
        .rd_en(s_rd[g]), .rd_data(s_data[g]),
        .wr_en(s_wr[g]), .wr_data(wr_data),
        .unf_ev(s_unf_ev[g]), .ovf_ev(s_ovf_ev[g]),
        .unf_flag(underflow[g]), .ovf_flag(overflow[g])
      );
    end
  endgenerate

  always_comb begin
    s0_val = '0;
    s1_val = '0;
    for (int s = 0; s < NSTR; s++) begin
      if (rd0_tgt == TW'(s + 1)) s0_val = s_data[s];
      if (rd1_tgt == TW'(s + 1)) s1_val = s_data[s];
    end
  end

  assign rd0_data = !rd0_en ? '0 : (rd0_hit ? s0_val : rf_rd0);
  assign rd1_data = !rd1_en ? '0 : (rd1_hit ? s1_val : rf_rd1);
endmodule

// File: rtl/regmap_chk.sv
module regmap_chk #(
  parameter int DW    = 32,
  parameter int NSPEC = 16,
  parameter int NSTR  = 5,
  localparam int SW   = $clog2(NSPEC),
  localparam int TW   = $clog2(NSTR + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd0_en,
  input logic [SW-1:0]            rd0_spec,
  input logic [DW-1:0]            rd0_data,
  input logic                     rd1_en,
  input logic [SW-1:0]            rd1_spec,
  input logic [DW-1:0]            rd1_data,
  input logic                     map_valid,
  input logic                     map_unmap,
  input logic [SW-1:0]            map_spec,
  input logic [TW-1:0]            map_target,
  input logic                     map_err,
  input logic [NSTR-1:0]          underflow,
  input logic [NSTR-1:0]          overflow,
  input logic                     map_accept,
  input logic [NSPEC-1:0]         ent_vld,
  input logic [NSPEC-1:0][TW-1:0] ent_tgt
);
  int per_str [NSTR];

  always_comb begin
    for (int s = 0; s < NSTR; s++) begin
      per_str[s] = 0;
      for (int e = 0; e < NSPEC; e++)
        if (ent_vld[e] && ent_tgt[e] == TW'(s + 1)) per_str[s] = per_str[s] + 1;
    end
  end

  a_r11_err_from_bind: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> $past(map_valid && !map_unmap));

  a_r11_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !map_unmap && (map_target == '0 || int'(map_target) > NSTR)) |=> map_err);

  a_r3_bind_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (map_accept && !map_unmap) |=> ent_vld[$past(map_spec)]);

  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(underflow) & ~underflow)) |-> $past(map_accept));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(overflow) & ~overflow)) |-> $past(map_accept));

  a_r10_same_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && rd1_en && rd0_spec == rd1_spec) |-> rd0_data == rd1_data);

  generate
    for (genvar g = 0; g < NSTR; g++) begin : g_excl
      a_r11_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        per_str[g] <= 1);
    end
  endgenerate
endmodule

bind regmap_unit regmap_chk #(.DW(DW), .NSPEC(NSPEC), .NSTR(NSTR)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .rd0_en(rd0_en), .rd0_spec(rd0_spec), .rd0_data(rd0_data),
  .rd1_en(rd1_en), .rd1_spec(rd1_spec), .rd1_data(rd1_data),
  .map_valid(map_valid), .map_unmap(map_unmap), .map_spec(map_spec),
  .map_target(map_target), .map_err(map_err),
  .underflow(underflow), .overflow(overflow),
  .map_accept(map_accept), .ent_vld(ent_vld), .ent_tgt(ent_tgt)
);

// File: tb/regmap_unit_tb_top.sv
`timescale 1ns/1ps
module regmap_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        rd0_en, rd1_en, wr_en, map_valid, map_unmap;
  logic [3:0]  rd0_spec, rd1_spec, wr_spec, map_spec, map_cfg;
  logic [2:0]  map_target;
  logic [31:0] wr_data;
  logic [31:0] a_rd0, a_rd1, b_rd0, b_rd1;
  logic        a_err, b_err;
  logic [4:0]  a_unf, a_ovf, b_unf, b_ovf;

  regmap_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(rd0_en), .rd0_spec(rd0_spec), .rd0_data(a_rd0),
    .rd1_en(rd1_en), .rd1_spec(rd1_spec), .rd1_data(a_rd1),
    .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
    .map_valid(map_valid), .map_unmap(map_unmap), .map_spec(map_spec),
    .map_cfg(map_cfg), .map_target(map_target), .map_err(a_err),
    .underflow(a_unf), .overflow(a_ovf)
  );

  regmap_unit #(.S4_STACK(1'b1)) dut_stk_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(rd0_en), .rd0_spec(rd0_spec), .rd0_data(b_rd0),
    .rd1_en(rd1_en), .rd1_spec(rd1_spec), .rd1_data(b_rd1),
    .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
    .map_valid(map_valid), .map_unmap(map_unmap), .map_spec(map_spec),
    .map_cfg(map_cfg), .map_target(map_target), .map_err(b_err),
    .underflow(b_unf), .overflow(b_ovf)
  );

  typedef struct {
    int          sel;
    logic [31:0] val;
    string       req;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam int S_ARD0 = 0, S_ARD1 = 1, S_BRD0 = 2, S_BRD1 = 3, S_AERR = 4,
                 S_AUNF = 5, S_AOVF = 6, S_BUNF = 7, S_BOVF = 8;

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      S_ARD0:  return a_rd0;
      S_ARD1:  return a_rd1;
      S_BRD0:  return b_rd0;
      S_BRD1:  return b_rd1;
      S_AERR:  return {31'd0, a_err};
      S_AUNF:  return {27'd0, a_unf};
      S_AOVF:  return {27'd0, a_ovf};
      S_BUNF:  return {27'd0, b_unf};
      default: return {27'd0, b_ovf};
    endcase
  endfunction

  task automatic expect_v(input int sel, input logic [31:0] v, input string req);
    item_t it;
    it.sel = sel;
    it.val = v;
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = observe(it.sel);
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    rd0_en = 0; rd1_en = 0; wr_en = 0; map_valid = 0; map_unmap = 0;
  endtask

  task automatic do_wr(input logic [3:0] s, input logic [31:0] d);
    tick();
    wr_en = 1; wr_spec = s; wr_data = d;
  endtask

  task automatic do_rd(input logic [3:0] s);
    tick();
    rd0_en = 1; rd0_spec = s;
  endtask

  task automatic do_map(input logic [3:0] s, input logic [3:0] cfg, input logic [2:0] t);
    tick();
    map_valid = 1; map_unmap = 0; map_spec = s; map_cfg = cfg; map_target = t;
  endtask

  task automatic do_unmap(input logic [3:0] s);
    tick();
    map_valid = 1; map_unmap = 1; map_spec = s; map_cfg = 0; map_target = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rd0_en = 0; rd1_en = 0; wr_en = 0; map_valid = 0; map_unmap = 0;
    rd0_spec = 0; rd1_spec = 0; wr_spec = 0; wr_data = 0;
    map_spec = 0; map_cfg = 0; map_target = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state and plain register file
    tick(); rd0_en = 1; rd0_spec = 3; rd1_en = 1; rd1_spec = 7;
    expect_v(S_ARD0, 0, "R1 reset r3");
    expect_v(S_ARD1, 0, "R1 reset r7");
    expect_v(S_AUNF, 0, "R9 reset unf");
    expect_v(S_AOVF, 0, "R9 reset ovf");
    expect_v(S_AERR, 0, "R11 reset err");
    do_wr(3, 32'h11);
    do_wr(7, 32'h22);
    do_wr(1, 32'h55);
    tick(); wr_en = 1; wr_spec = 3; wr_data = 32'h33;
    rd0_en = 1; rd0_spec = 3; rd1_en = 1; rd1_spec = 7;
    expect_v(S_ARD0, 32'h11, "R1 old value before edge");
    expect_v(S_ARD1, 32'h22, "R1 read r7");
    do_rd(3); expect_v(S_ARD0, 32'h33, "R1 write at edge");
    expect_v(S_ARD1, 0, "R1 disabled port zero");

    // R3 R5 delay queue depth 3 on structure 1
    do_map(1, 3, 1);
    do_wr(1, 32'd10); expect_v(S_AERR, 0, "R11 accepted bind no err");
    do_rd(1); expect_v(S_ARD0, 0, "R5 R9 not yet filled");
    do_wr(1, 32'd20);
    expect_v(S_AUNF, 5'b00001, "R9 underflow bit0");
    expect_v(S_BUNF, 5'b00001, "R9 underflow bit0 b");
    do_wr(1, 32'd30);
    do_rd(1); expect_v(S_ARD0, 32'd10, "R5 value three writes back");
    tick(); rd0_en = 1; rd0_spec = 1; rd1_en = 1; rd1_spec = 1;
    expect_v(S_ARD0, 32'd10, "R5 no pop port0");
    expect_v(S_ARD1, 32'd10, "R5 R10 no pop port1");
    do_wr(1, 32'd40);
    do_rd(1); expect_v(S_ARD0, 32'd20, "R5 oldest discarded");
    do_unmap(1);
    do_rd(1); expect_v(S_ARD0, 32'h55, "R2 R3 rf kept while bound");

    // R6 R7 R9 R10 structure 4, fifo in dut_i, stack in dut_stk_i
    do_map(4, 2, 4);
    do_wr(4, 32'd1);
    do_wr(4, 32'd2);
    do_wr(4, 32'd3);
    tick(); rd0_en = 1; rd0_spec = 4; rd1_en = 1; rd1_spec = 4;
    expect_v(S_AOVF, 5'b01000, "R9 overflow fifo");
    expect_v(S_BOVF, 5'b01000, "R9 overflow stack");
    expect_v(S_ARD0, 32'd1, "R6 R10 fifo head p0");
    expect_v(S_ARD1, 32'd1, "R6 R10 fifo head p1");
    expect_v(S_BRD0, 32'd2, "R7 R10 stack top p0");
    expect_v(S_BRD1, 32'd2, "R7 R10 stack top p1");
    do_rd(4);
    expect_v(S_ARD0, 32'd2, "R6 R10 single pop fifo");
    expect_v(S_BRD0, 32'd1, "R7 R10 single pop stack");
    do_rd(4);
    expect_v(S_ARD0, 0, "R9 empty fifo zero");
    expect_v(S_BRD0, 0, "R9 empty stack zero");
    tick();
    expect_v(S_AUNF, 5'b01001, "R9 underflow bit3");
    expect_v(S_BUNF, 5'b01001, "R9 underflow bit3 b");

    // R12 rebinding clears state and flags
    do_map(4, 2, 4);
    tick();
    expect_v(S_AOVF, 0, "R12 R9 ovf cleared");
    expect_v(S_AUNF, 5'b00001, "R12 R9 unf bit3 cleared");
    do_wr(4, 32'd9);
    do_rd(4); expect_v(S_ARD0, 32'd9, "R12 fresh fifo");
    expect_v(S_BRD0, 32'd9, "R12 fresh stack");

    // R4 R8 circular buffer, depth setting 0 gives 8
    do_map(5, 0, 5);
    for (int i = 0; i < 9; i++) do_wr(5, 32'd100 + i);
    do_rd(5); expect_v(S_ARD0, 32'd108, "R4 R8 wrapped write");
    for (int i = 1; i < 8; i++) begin
      do_rd(5); expect_v(S_ARD0, 32'd100 + i, "R8 ring order");
    end
    do_rd(5); expect_v(S_ARD0, 32'd108, "R8 read pointer wrap");

    // R4 depth setting above 8 on structure 2
    do_map(6, 12, 2);
    for (int i = 0; i < 7; i++) do_wr(6, 32'd200 + i);
    do_rd(6); expect_v(S_ARD0, 0, "R4 depth 8 not yet reached");
    do_wr(6, 32'd207);
    do_rd(6); expect_v(S_ARD0, 32'd200, "R4 depth 8 reached");

    // R11 rejected commands
    do_map(9, 1, 5);
    tick(); expect_v(S_AERR, 1, "R11 busy target");
    expect_v(S_BRD0, 0, "R11 idle port");
    do_map(9, 1, 0);
    tick(); expect_v(S_AERR, 1, "R11 target zero");
    do_map(9, 1, 6);
    tick(); expect_v(S_AERR, 1, "R11 target six");
    tick(); expect_v(S_AERR, 0, "R11 pulse one cycle");
    do_wr(9, 32'd66);
    do_rd(9); expect_v(S_ARD0, 32'd66, "R11 rejected bind left rf");
    do_rd(5); expect_v(S_ARD0, 32'd101, "R11 owner kept");
    do_map(9, 1, 3);
    do_wr(9, 32'd77); expect_v(S_AERR, 0, "R11 free target accepted");
    do_rd(9); expect_v(S_ARD0, 32'd77, "R5 depth one");
    do_unmap(9);
    do_rd(9); expect_v(S_ARD0, 32'd66, "R2 rf untouched by bound write");

    tick();
    tick();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule